// File: doc/BRIEF.md
# TLP Header Trace Filter

This block sits beside a PCIe core's packet path and decides, one header at a time, whether a transaction-layer packet should be handed on for tracing. Each observed packet arrives with a descriptor: its 16-bit requester ID, the index of the core port it passed through, its class (posted, non-posted or completion), its direction relative to the core, and, for inbound completions, which of two completion subclasses it belongs to. When a packet qualifies, the block raises a one-cycle capture strobe with the packet header beside it, one clock after the packet was presented.

Four static settings steer the decision. A 20-bit filter word selects either a single requester or any set of core ports. An 8-bit class mask picks the packet classes. A 4-bit direction code chooses which directions and completion subclasses are wanted. A format select (compact 4DW or full 8DW record) changes what each direction code means. The settings are taken in only while tracing is off. An illegal combination raises a configuration-error flag and blocks all capture. A small controller with three states tracks tracing. `ST_IDLE` means tracing is off and the settings are being sampled. `ST_RUN` means tracing is on with legal settings. `ST_FAULT` means tracing is on with illegal settings. The transitions are `ST_IDLE`→`ST_RUN` when trace_en rises with no error, `ST_IDLE`→`ST_FAULT` when trace_en rises with an error, and `ST_RUN`→`ST_IDLE` or `ST_FAULT`→`ST_IDLE` when trace_en falls. Only `ST_RUN` with trace_en still high can capture.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset cap_vld is 0, cap_hdr is 0 and cfg_err is 1, because the held settings reset to all zeros (filter 0, class mask 0, direction 0, 4DW format), and an empty class mask is illegal.
- R2: When filter bit 19 is 0 (requester mode), a packet passes the filter only if pkt_rid equals filter bits [15:0] exactly.
- R3: When filter bit 19 is 1 (port mode), a packet passes the filter if filter bit number pkt_port within bits [15:0] is 1, so several ports can be selected at once.
- R4: Class mask bit 0 selects posted (pkt_cls 0), bit 1 selects non-posted (pkt_cls 1) and bit 2 selects completion (pkt_cls 2). pkt_cls 3 never matches.
- R5: With cfg_fmt8=0 (4DW), the direction codes mean: 0 is inbound of every class. 1 is outbound of every class. 2 is outbound of every class plus inbound posted, non-posted and completions with pkt_cpl_b=1. 3 is outbound of every class plus inbound completions with pkt_cpl_b=0.
- R6: With cfg_fmt8=1 (8DW), the direction codes mean: 1 is outbound of every class. 2 is inbound posted, non-posted and completions with pkt_cpl_b=1. 3 is inbound completions with pkt_cpl_b=0 only.
- R7: cfg_err is 1 in any of these cases: filter bits [18:16] are nonzero; class mask bits [2:0] are all zero; class mask bits [7:3] are nonzero; the direction code exceeds 3; direction 0 is used with 8DW; more than one class bit is set with a direction that includes outbound (code 1, or code 2 or 3 with 4DW). While cfg_err is 1, cap_vld stays 0.
- R8: The settings and cfg_err are sampled on every clock edge at which trace_en is 0, and cfg_err shows the result one cycle later. Changes to the settings while trace_en is 1 have no effect on matching or on cfg_err.
- R9: A packet with pkt_vld=1 that passes the filter, class and direction checks, presented while tracing runs, gives cap_vld=1 on the next cycle with cap_hdr equal to its pkt_hdr. cap_hdr holds its last captured value whenever cap_vld is 0.
- R10: No packet is captured in a cycle where trace_en is 0, nor in the first cycle in which trace_en is 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Tracing enable; settings are sampled while low |
| cfg_filter | input | 20 | Filter word: bit 19 mode, bits 18:16 reserved, bits 15:0 value |
| cfg_types | input | 8 | Class mask, one bit per class |
| cfg_dir | input | 4 | Direction code |
| cfg_fmt8 | input | 1 | Format select: 0 = 4DW, 1 = 8DW |
| pkt_vld | input | 1 | Packet descriptor valid |
| pkt_rid | input | 16 | Requester ID of the packet |
| pkt_port | input | PORT_W | Core port index of the packet |
| pkt_cls | input | 2 | Packet class: 0 posted, 1 non-posted, 2 completion |
| pkt_outb | input | 1 | 1 = outbound, 0 = inbound |
| pkt_cpl_b | input | 1 | Inbound completion subclass: 1 = B, 0 = A |
| pkt_hdr | input | HDR_W | Packet header passed to the capture output |
| cap_vld | output | 1 | One-cycle capture strobe |
| cap_hdr | output | HDR_W | Header of the most recent captured packet |
| cfg_err | output | 1 | The held settings are illegal |

## Verification
Two events can fall in the same cycle: a qualifying packet, and a change of the enable or of the settings. The bench provokes this in three ways. It presents a matching packet in the very cycle trace_en rises. It presents one in the cycle trace_en falls. It changes the settings inputs to a conflicting filter while a packet arrives with tracing running. In each case the strobe and the error flag on the following cycle are compared with the values that the held settings and R8 and R10 predict. Randomized settings and packets, including illegal combinations, are then checked against the bench's own model of the rules.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;

    localparam int FILT_W   = 20;
    localparam int FVAL_W   = 16;
    localparam int MODE_BIT = 19;
    localparam int TYPE_W   = 8;
    localparam int NCLS     = 3;
    localparam int DIR_W    = 4;

    typedef enum logic [1:0] {
        CLS_P    = 2'd0,
        CLS_NP   = 2'd1,
        CLS_CPL  = 2'd2,
        CLS_RSVD = 2'd3
    } tlp_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } trace_st_e;

    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic [TYPE_W-1:0] tmask;
        logic [DIR_W-1:0]  dir;
        logic              fmt8;
    } trace_cfg_t;

endpackage

// File: rtl/ttf_cfg_reg.sv
module ttf_cfg_reg
    import tlp_trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  trace_cfg_t cfg_i,
    output trace_cfg_t cfg_q,
    output logic       err_q
);

    logic rsvd_bad;
    logic empty_mask;
    logic high_mask;
    logic dir_range;
    logic dir0_fmt8;
    logic incl_out;
    logic multi_out;
    logic bad;

    always_comb begin
        rsvd_bad   = |cfg_i.filt[MODE_BIT-1:FVAL_W];
        empty_mask = ~|cfg_i.tmask[NCLS-1:0];
        high_mask  = |cfg_i.tmask[TYPE_W-1:NCLS];
        dir_range  = |cfg_i.dir[DIR_W-1:2];
        dir0_fmt8  = cfg_i.fmt8 && (cfg_i.dir == '0);
        incl_out   = (cfg_i.dir == DIR_W'(1)) ||
                     (!cfg_i.fmt8 && ((cfg_i.dir == DIR_W'(2)) || (cfg_i.dir == DIR_W'(3))));
        multi_out  = incl_out && ($countones(cfg_i.tmask[NCLS-1:0]) > 1);
        bad        = rsvd_bad | empty_mask | high_mask | dir_range | dir0_fmt8 | multi_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            err_q <= 1'b1;
        end else if (load) begin
            cfg_q <= cfg_i;
            err_q <= bad;
        end
    end

endmodule

// File: rtl/ttf_matcher.sv
module ttf_matcher
    import tlp_trace_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  trace_cfg_t        cfg,
    input  logic [FVAL_W-1:0] rid,
    input  logic [PORT_W-1:0] port,
    input  tlp_cls_e          cls,
    input  logic              outb,
    input  logic              cpl_b,
    output logic              hit
);

    localparam int NPORT = 1 << PORT_W;

    logic [NCLS-1:0] cls_sel;
    logic            filt_ok;
    logic            type_ok;
    logic            dir_ok;
    logic            in_npb;
    logic            in_a;
    logic            port_ok;

    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        assign cls_sel[k] = cfg.tmask[k] && (cls == tlp_cls_e'(k));
    end

    always_comb begin
        port_ok = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if ((p < FVAL_W) && (port == PORT_W'(p))) begin
                port_ok = cfg.filt[p];
            end
        end
    end

    always_comb begin
        if (cfg.filt[MODE_BIT]) begin
            filt_ok = port_ok;
        end else begin
            filt_ok = (rid == cfg.filt[FVAL_W-1:0]);
        end
        type_ok = |cls_sel;
        in_npb  = !outb && ((cls != CLS_CPL) || cpl_b);
        in_a    = !outb && (cls == CLS_CPL) && !cpl_b;
        unique case ({cfg.fmt8, cfg.dir})
            5'h00:   dir_ok = !outb;
            5'h01:   dir_ok = outb;
            5'h02:   dir_ok = outb || in_npb;
            5'h03:   dir_ok = outb || in_a;
            5'h11:   dir_ok = outb;
            5'h12:   dir_ok = in_npb;
            5'h13:   dir_ok = in_a;
            default: dir_ok = 1'b0;
        endcase
        hit = filt_ok && type_ok && dir_ok;
    end

endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
    import tlp_trace_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int HDR_W  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic [19:0]       cfg_filter,
    input  logic [7:0]        cfg_types,
    input  logic [3:0]        cfg_dir,
    input  logic              cfg_fmt8,
    input  logic              pkt_vld,
    input  logic [15:0]       pkt_rid,
    input  logic [PORT_W-1:0] pkt_port,
    input  logic [1:0]        pkt_cls,
    input  logic              pkt_outb,
    input  logic              pkt_cpl_b,
    input  logic [HDR_W-1:0]  pkt_hdr,
    output logic              cap_vld,
    output logic [HDR_W-1:0]  cap_hdr,
    output logic              cfg_err
);

    trace_cfg_t cfg_in;
    trace_cfg_t cfg_held;
    logic       err_held;
    logic       hit;
    logic       elig;
    trace_st_e  st_q;
    trace_st_e  st_d;

    assign cfg_in = '{filt: cfg_filter, tmask: cfg_types, dir: cfg_dir, fmt8: cfg_fmt8};

    ttf_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!trace_en),
        .cfg_i (cfg_in),
        .cfg_q (cfg_held),
        .err_q (err_held)
    );

    ttf_matcher #(.PORT_W(PORT_W)) u_match (
        .cfg   (cfg_held),
        .rid   (pkt_rid),
        .port  (pkt_port),
        .cls   (tlp_cls_e'(pkt_cls)),
        .outb  (pkt_outb),
        .cpl_b (pkt_cpl_b),
        .hit   (hit)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (trace_en) begin
                    st_d = err_held ? ST_FAULT : ST_RUN;
                end
            end
            ST_RUN, ST_FAULT: begin
                if (!trace_en) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign elig = (st_q == ST_RUN) && trace_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_hdr <= '0;
        end else begin
            cap_vld <= elig && pkt_vld && hit;
            if (elig && pkt_vld && hit) begin
                cap_hdr <= pkt_hdr;
            end
        end
    end

    assign cfg_err = err_held;

endmodule

// File: rtl/ttf_checker.sv
module ttf_checker #(
    parameter int HDR_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trace_en,
    input logic             pkt_vld,
    input logic [HDR_W-1:0] pkt_hdr,
    input logic             cap_vld,
    input logic [HDR_W-1:0] cap_hdr,
    input logic             cfg_err
);

    AST_ERR_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> !cfg_err); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        trace_en |=> $stable(cfg_err)); // R8

    AST_CAP_FROM_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> ($past(pkt_vld) && $past(trace_en))); // R9

    AST_HDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> (cap_hdr == $past(pkt_hdr))); // R9

    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld |-> $stable(cap_hdr)); // R9

    AST_ENABLE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> $past(trace_en, 2)); // R10

endmodule

bind tlp_trace_filter ttf_checker #(.HDR_W(HDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trace_en (trace_en),
    .pkt_vld  (pkt_vld),
    .pkt_hdr  (pkt_hdr),
    .cap_vld  (cap_vld),
    .cap_hdr  (cap_hdr),
    .cfg_err  (cfg_err)
);

// File: tb/tlp_trace_filter_bench.sv
module tlp_trace_filter_bench;

    localparam int PORT_W = 4;
    localparam int HDR_W  = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trace_en = 1'b0;
    logic [19:0]       cfg_filter = '0;
    logic [7:0]        cfg_types = '0;
    logic [3:0]        cfg_dir = '0;
    logic              cfg_fmt8 = 1'b0;
    logic              pkt_vld = 1'b0;
    logic [15:0]       pkt_rid = '0;
    logic [PORT_W-1:0] pkt_port = '0;
    logic [1:0]        pkt_cls = '0;
    logic              pkt_outb = 1'b0;
    logic              pkt_cpl_b = 1'b0;
    logic [HDR_W-1:0]  pkt_hdr = '0;
    logic              cap_vld;
    logic [HDR_W-1:0]  cap_hdr;
    logic              cfg_err;

    int n_checks = 0;
    int n_errors = 0;

    logic [19:0]      m_f;
    logic [7:0]       m_t;
    logic [3:0]       m_d;
    logic             m_f8;
    logic [HDR_W-1:0] last_cap = '0;

    always #10 clk = ~clk;

    tlp_trace_filter #(.PORT_W(PORT_W), .HDR_W(HDR_W)) u_tlp_trace_filter (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
        .cfg_filter(cfg_filter), .cfg_types(cfg_types), .cfg_dir(cfg_dir), .cfg_fmt8(cfg_fmt8),
        .pkt_vld(pkt_vld), .pkt_rid(pkt_rid), .pkt_port(pkt_port), .pkt_cls(pkt_cls),
        .pkt_outb(pkt_outb), .pkt_cpl_b(pkt_cpl_b), .pkt_hdr(pkt_hdr),
        .cap_vld(cap_vld), .cap_hdr(cap_hdr), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input logic [HDR_W-1:0] act,
                       input logic [HDR_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_err(input logic [19:0] f, input logic [7:0] t,
                                 input logic [3:0] d, input logic f8);
        bit out_incl;
        int nb;
        nb = int'(t[0]) + int'(t[1]) + int'(t[2]);
        out_incl = (d == 4'd1) || (!f8 && (d == 4'd2 || d == 4'd3));
        return (f[18:16] != 0) || (t[2:0] == 0) || (t[7:3] != 0) || (d > 4'd3) ||
               (f8 && d == 4'd0) || (out_incl && nb > 1);
    endfunction

    function automatic bit m_hit(input logic [15:0] rid, input logic [PORT_W-1:0] port,
                                 input logic [1:0] cls, input logic outb, input logic cb);
        bit fo, to, dok, inb, ina;
        fo  = m_f[19] ? m_f[port] : (rid == m_f[15:0]);
        to  = (cls != 2'd3) && m_t[cls];
        inb = !outb && (cls != 2'd2 || cb);
        ina = !outb && cls == 2'd2 && !cb;
        case ({m_f8, m_d})
            5'h00:   dok = !outb;
            5'h01:   dok = outb;
            5'h02:   dok = outb || inb;
            5'h03:   dok = outb || ina;
            5'h11:   dok = outb;
            5'h12:   dok = inb;
            5'h13:   dok = ina;
            default: dok = 1'b0;
        endcase
        return fo && to && dok && !m_err(m_f, m_t, m_d, m_f8);
    endfunction

    // Called at a negedge; leaves tracing enabled, one negedge after enable.
    task automatic setup(input logic [19:0] f, input logic [7:0] t, input logic [3:0] d,
                         input logic f8, input string req);
        trace_en = 1'b0; pkt_vld = 1'b0;
        cfg_filter = f; cfg_types = t; cfg_dir = d; cfg_fmt8 = f8;
        @(negedge clk);
        m_f = f; m_t = t; m_d = d; m_f8 = f8;
        chk(cfg_err == m_err(f, t, d, f8), req, HDR_W'(cfg_err), HDR_W'(m_err(f, t, d, f8)));
        trace_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic pkt(input logic [15:0] rid, input logic [PORT_W-1:0] port,
                       input logic [1:0] cls, input logic outb, input logic cb,
                       input bit exp, input string req);
        logic [HDR_W-1:0] h;
        h = {$urandom, $urandom, $urandom, $urandom};
        pkt_vld = 1'b1; pkt_rid = rid; pkt_port = port; pkt_cls = cls;
        pkt_outb = outb; pkt_cpl_b = cb; pkt_hdr = h;
        @(negedge clk);
        pkt_vld = 1'b0;
        chk(cap_vld == exp, req, HDR_W'(cap_vld), HDR_W'(exp));
        if (exp) begin
            last_cap = h;
        end
        chk(cap_hdr == last_cap, {req, " hdr"}, cap_hdr, last_cap);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(cap_vld == 1'b0, "R1 cap_vld", HDR_W'(cap_vld), '0);
        chk(cfg_err == 1'b1, "R1 cfg_err", HDR_W'(cfg_err), HDR_W'(1));
        chk(cap_hdr == '0, "R1 cap_hdr", cap_hdr, '0);

        // R2 requester mode
        setup(20'h00101, 8'h07, 4'd0, 1'b0, "R2 cfg");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R2 exact rid");
        pkt(16'h0100, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 other rid");
        pkt(16'h0101, 4'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R5 outbound under code0");

        // R3 port mode, ports 1 and 4
        setup(20'h80012, 8'h07, 4'd0, 1'b0, "R3 cfg");
        pkt(16'h1234, 4'd1, 2'd0, 1'b0, 1'b0, 1'b1, "R3 port1");
        pkt(16'h0000, 4'd4, 2'd2, 1'b0, 1'b1, 1'b1, "R3 port4");
        pkt(16'h1234, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, "R3 port2");

        // R4 class mask
        setup(20'h00101, 8'h05, 4'd0, 1'b0, "R4 cfg");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R4 posted");
        pkt(16'h0101, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0, "R4 nonposted");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b0, 1'b1, "R4 completion");
        pkt(16'h0101, 4'd0, 2'd3, 1'b0, 1'b0, 1'b0, "R4 class3");

        // R5 4DW codes
        setup(20'h00101, 8'h01, 4'd2, 1'b0, "R5 cfg2p");
        pkt(16'h0101, 4'd0, 2'd0, 1'b1, 1'b0, 1'b1, "R5 c2 out P");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R5 c2 in P");
        setup(20'h00101, 8'h04, 4'd2, 1'b0, "R5 cfg2c");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b1, 1'b1, "R5 c2 in cplB");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b0, 1'b0, "R5 c2 in cplA");
        pkt(16'h0101, 4'd0, 2'd2, 1'b1, 1'b0, 1'b1, "R5 c2 out cpl");
        setup(20'h00101, 8'h04, 4'd3, 1'b0, "R5 cfg3");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b0, 1'b1, "R5 c3 in cplA");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b1, 1'b0, "R5 c3 in cplB");
        pkt(16'h0101, 4'd0, 2'd2, 1'b1, 1'b1, 1'b1, "R5 c3 out cpl");
        setup(20'h00101, 8'h02, 4'd1, 1'b0, "R5 cfg1");
        pkt(16'h0101, 4'd0, 2'd1, 1'b1, 1'b0, 1'b1, "R5 c1 out NP");
        pkt(16'h0101, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0, "R5 c1 in NP");

        // R6 8DW codes
        setup(20'h00101, 8'h07, 4'd2, 1'b1, "R6 cfg2");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R6 c2 in P");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b1, 1'b1, "R6 c2 in cplB");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b0, 1'b0, "R6 c2 in cplA");
        pkt(16'h0101, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0, "R6 c2 out P");
        setup(20'h00101, 8'h04, 4'd3, 1'b1, "R6 cfg3");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b0, 1'b1, "R6 c3 in cplA");
        pkt(16'h0101, 4'd0, 2'd2, 1'b0, 1'b1, 1'b0, "R6 c3 in cplB");
        pkt(16'h0101, 4'd0, 2'd2, 1'b1, 1'b0, 1'b0, "R6 c3 out cpl");
        setup(20'h00101, 8'h02, 4'd1, 1'b1, "R6 cfg1");
        pkt(16'h0101, 4'd0, 2'd1, 1'b1, 1'b0, 1'b1, "R6 c1 out NP");

        // R7 illegal settings: flag set and nothing captured
        setup(20'h10101, 8'h07, 4'd0, 1'b0, "R7 reserved bits");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R7 reserved no cap");
        setup(20'h00101, 8'h00, 4'd0, 1'b0, "R7 empty mask");
        setup(20'h00101, 8'h09, 4'd0, 1'b0, "R7 high mask");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R7 high mask no cap");
        setup(20'h00101, 8'h03, 4'd1, 1'b0, "R7 multi outbound");
        pkt(16'h0101, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0, "R7 multi outbound no cap");
        setup(20'h00101, 8'h03, 4'd2, 1'b0, "R7 multi 4DW code2");
        setup(20'h00101, 8'h03, 4'd2, 1'b1, "R7 multi 8DW code2 legal");
        setup(20'h00101, 8'h07, 4'd0, 1'b1, "R7 dir0 8DW");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R7 dir0 8DW no cap");
        setup(20'h00101, 8'h01, 4'd5, 1'b0, "R7 dir range");

        // R8 settings changed while running are ignored
        setup(20'h00101, 8'h07, 4'd0, 1'b0, "R8 cfg");
        cfg_filter = 20'h00202; cfg_types = 8'h00; cfg_dir = 4'd9;
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R8 old filter kept");
        pkt(16'h0202, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R8 new filter ignored");
        chk(cfg_err == 1'b0, "R8 err frozen", HDR_W'(cfg_err), '0);

        // R10 enable edges, R9 header hold
        setup(20'h00101, 8'h07, 4'd0, 1'b0, "R10 cfg");
        trace_en = 1'b0;
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R10 disable cycle");
        trace_en = 1'b1;
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R10 first enable cycle");
        pkt(16'h0101, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R9 after enable");
        pkt(16'h0102, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R9 hold");

        // Random settings and packets against the model (R2..R9)
        for (int c = 0; c < 150; c++) begin
            logic [19:0] f;
            logic [7:0]  t;
            logic [3:0]  d;
            logic [15:0] rids [4];
            rids[0] = 16'h0101; rids[1] = 16'h0200; rids[2] = 16'hBEEF; rids[3] = 16'h0001;
            if ($urandom % 2 == 1) f = {4'h8, 16'($urandom)};
            else f = {4'h0, rids[$urandom % 4]};
            if ($urandom % 16 == 0) f[18:16] = 3'($urandom);
            t = 8'($urandom % 8);
            if ($urandom % 16 == 0) t[7:3] = 5'($urandom);
            d = ($urandom % 16 == 0) ? 4'($urandom) : 4'($urandom % 4);
            setup(f, t, d, 1'($urandom), "R7 random cfg");
            for (int p = 0; p < 16; p++) begin
                logic [15:0]       r;
                logic [PORT_W-1:0] po;
                logic [1:0]        cl;
                logic              ob, cb;
                r  = rids[$urandom % 4];
                po = PORT_W'($urandom);
                cl = 2'($urandom);
                ob = 1'($urandom);
                cb = 1'($urandom);
                pkt(r, po, cl, ob, cb, m_hit(r, po, cl, ob, cb), "R9 random pkt");
            end
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule